// File: doc/BRIEF.md
# Configuration Access PIO Engine

This block lets a host processor issue a single PCIe configuration read or write at a time through a small register file. Software first programs a transaction kind, a target address, the write data and the byte-lane strobes. It then writes 1 to a launch register. The engine copies the programmed fields into a held request and offers that request on a valid/ready request port toward the link side. Once the request is accepted, the engine waits on a valid/ready completion port for a status code and read data.

When the completion arrives, or when a bounded wait runs out, the engine stores the outcome in three places: a status register, a read-data register and a sticky done flag. It also clears the launch register. Software polls until the launch register reads 0 and the done flag reads 1, reads the result, and then writes 1 to the flag to clear it.

Back-pressure rules:
- Request port: `req_valid` stays high with a stable payload until `req_ready` is seen high at a clock edge. The only other way it drops is a timeout.
- Completion port: `cpl_ready` is high only while the engine is waiting for a completion. A completion is taken in the cycle where both `cpl_valid` and `cpl_ready` are high.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, the launch register and done flag read 0, the status register reads 0, the read-data register reads 0xFFFFFFFF, and `req_valid`, `cpl_ready` and `irq` are low.
- R2: Writing a value with bit 0 set to the launch register while idle makes it read 1 and raises `req_valid` from the next cycle. The request carries:
  - the kind from control bits 3:0;
  - the window-bypass flag from control bit 24;
  - the data register;
  - an address of {high address register, low address register with bits 1:0 forced to 0}.
- R3: While `req_valid` is high and `req_ready` is low, the request and its payload hold. After acceptance, `req_valid` falls and `cpl_ready` is high until the request finishes. The two are never high together.
- R4: For kinds 0x8 and 0x9 (configuration reads, type 0 and type 1), `req_strb` is 0xF whatever the strobe register holds. For every other kind it equals the strobe register bits 3:0.
- R5: When a completion is taken, the same clock edge does all of the following:
  - the launch register returns to 0;
  - the done flag becomes 1;
  - status bits 9:7 take `cpl_code` (0 ok, 1 unsupported, 2 retry, 4 abort);
  - status bit 0 becomes 1 exactly when the kind is one of 0x8 to 0xB (configuration reads and writes, all non-posted).
- R6: The read-data register takes `cpl_data` only when the completion code is 0. Any other outcome sets it to 0xFFFFFFFF.
- R7: If the request has not finished TIMEOUT_CYCLES cycles after the launch edge, the engine finishes it with code 4, read data 0xFFFFFFFF, the launch register at 0 and the done flag at 1. This holds whether the request is still unaccepted or is waiting for a completion. A completion taken in the last cycle of that window wins over the timeout.
- R8: A launch write while a request is in flight, or a launch write with bit 0 clear, has no effect: no second request appears.
- R9: Writing 1 to done-flag bit 0 clears the flag, and writing 0 leaves it unchanged. `irq` follows the flag.
- R10: Register word offsets on `reg_addr`:
  - 0 control (readable, bits 3:0 and 24);
  - 1 status (read-only);
  - 2 low address and 3 high address;
  - 4 write data;
  - 5 strobe (bits 3:0);
  - 6 read data (read-only);
  - 7 launch;
  - 8 done flag.

  Reads are combinational and have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Done flag |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted |
| req_kind | output | 4 | Transaction kind |
| req_addr | output | 64 | Dword-aligned target address |
| req_data | output | 32 | Write data |
| req_strb | output | 4 | Byte-lane strobes |
| req_nowin | output | 1 | Bypass address-window translation |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion accepted |
| cpl_code | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion read data |

## Verification
A sequencer stuck outside its idle state shows up at once: the launch register stays at 1, and `req_valid` or `cpl_ready` stays high. A stale or miscounted timeout counter shows up as the done flag arriving one cycle early or late against the TIMEOUT_CYCLES window. A wrong capture path is visible on the first completion through the status or read-data register, and a wrong request payload is visible on the request port in the cycle after launch.

// File: rtl/cfgpio_pkg.sv
package cfgpio_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 4;
  localparam int KIND_W = 4;
  localparam int STRB_W = WORD_W / 8;
  localparam int CODE_W = 3;

  localparam logic [REG_AW-1:0] OFF_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] OFF_STAT    = 4'd1;
  localparam logic [REG_AW-1:0] OFF_ADDR_LO = 4'd2;
  localparam logic [REG_AW-1:0] OFF_ADDR_HI = 4'd3;
  localparam logic [REG_AW-1:0] OFF_WDATA   = 4'd4;
  localparam logic [REG_AW-1:0] OFF_STRB    = 4'd5;
  localparam logic [REG_AW-1:0] OFF_RDATA   = 4'd6;
  localparam logic [REG_AW-1:0] OFF_LAUNCH  = 4'd7;
  localparam logic [REG_AW-1:0] OFF_FLAG    = 4'd8;

  localparam int CTRL_NOWIN_BIT = 24;
  localparam int STAT_CODE_LSB  = 7;

  localparam logic [KIND_W-1:0] KIND_CFG_RD0 = 4'h8;
  localparam logic [KIND_W-1:0] KIND_CFG_RD1 = 4'h9;

  localparam logic [CODE_W-1:0] CODE_OK    = 3'd0;
  localparam logic [CODE_W-1:0] CODE_ABORT = 3'd4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_WAIT} sq_state_t;

  typedef struct packed {
    logic [KIND_W-1:0]   kind;
    logic                nowin;
    logic [2*WORD_W-1:0] addr;
    logic [WORD_W-1:0]   data;
    logic [STRB_W-1:0]   strb;
  } pio_req_t;

  function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
    return (k == KIND_CFG_RD0) || (k == KIND_CFG_RD1);
  endfunction

  function automatic logic kind_is_nonposted(input logic [KIND_W-1:0] k);
    return k[KIND_W-1:KIND_W-2] == 2'b10;
  endfunction
endpackage

// File: rtl/cfgpio_regs.sv
module cfgpio_regs
  import cfgpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              launch_o,
  output pio_req_t          cfg_o,
  output logic              start_o,
  output logic              flag_o,
  input  logic              done_i,
  input  logic [CODE_W-1:0] done_code_i,
  input  logic              done_np_i,
  input  logic [WORD_W-1:0] done_data_i
);
  logic [KIND_W-1:0] ctrl_kind;
  logic              ctrl_nowin;
  logic [WORD_W-1:0] addr_lo, addr_hi, wdat_q, rdat_q;
  logic [STRB_W-1:0] strb_q;
  logic [CODE_W-1:0] stat_code;
  logic              stat_np, start_q, flag_q;
  logic              hit_ctrl, hit_lo, hit_hi, hit_wd, hit_strb, hit_launch, hit_flag;

  always_comb begin
    hit_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
    hit_lo     = bus_wr && (bus_addr == OFF_ADDR_LO);
    hit_hi     = bus_wr && (bus_addr == OFF_ADDR_HI);
    hit_wd     = bus_wr && (bus_addr == OFF_WDATA);
    hit_strb   = bus_wr && (bus_addr == OFF_STRB);
    hit_launch = bus_wr && (bus_addr == OFF_LAUNCH);
    hit_flag   = bus_wr && (bus_addr == OFF_FLAG);
  end

  assign launch_o = hit_launch && bus_wdata[0] && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_kind  <= '0;
      ctrl_nowin <= 1'b0;
      addr_lo    <= '0;
      addr_hi    <= '0;
      wdat_q     <= '0;
      strb_q     <= '0;
      stat_code  <= '0;
      stat_np    <= 1'b0;
      rdat_q     <= '1;
      start_q    <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        ctrl_kind  <= bus_wdata[KIND_W-1:0];
        ctrl_nowin <= bus_wdata[CTRL_NOWIN_BIT];
      end
      if (hit_lo)   addr_lo <= bus_wdata;
      if (hit_hi)   addr_hi <= bus_wdata;
      if (hit_wd)   wdat_q  <= bus_wdata;
      if (hit_strb) strb_q  <= bus_wdata[STRB_W-1:0];
      if (launch_o)    start_q <= 1'b1;
      else if (done_i) start_q <= 1'b0;
      if (done_i)                      flag_q <= 1'b1;
      else if (hit_flag && bus_wdata[0]) flag_q <= 1'b0;
      if (done_i) begin
        stat_code <= done_code_i;
        stat_np   <= done_np_i;
        rdat_q    <= (done_code_i == CODE_OK) ? done_data_i : '1;
      end
    end
  end

  always_comb begin
    cfg_o.kind  = ctrl_kind;
    cfg_o.nowin = ctrl_nowin;
    cfg_o.addr  = {addr_hi, addr_lo[WORD_W-1:2], 2'b00};
    cfg_o.data  = wdat_q;
    cfg_o.strb  = strb_q;
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL:    bus_rdata = {{(WORD_W-CTRL_NOWIN_BIT-1){1'b0}}, ctrl_nowin,
                                {(CTRL_NOWIN_BIT-KIND_W){1'b0}}, ctrl_kind};
      OFF_STAT:    bus_rdata = {{(WORD_W-STAT_CODE_LSB-CODE_W){1'b0}}, stat_code,
                                {(STAT_CODE_LSB-1){1'b0}}, stat_np};
      OFF_ADDR_LO: bus_rdata = addr_lo;
      OFF_ADDR_HI: bus_rdata = addr_hi;
      OFF_WDATA:   bus_rdata = wdat_q;
      OFF_STRB:    bus_rdata = {{(WORD_W-STRB_W){1'b0}}, strb_q};
      OFF_RDATA:   bus_rdata = rdat_q;
      OFF_LAUNCH:  bus_rdata = {{(WORD_W-1){1'b0}}, start_q};
      OFF_FLAG:    bus_rdata = {{(WORD_W-1){1'b0}}, flag_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign start_o = start_q;
  assign flag_o  = flag_q;

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (flag_q && !start_q)); // R5
  AST_ERR_RDATA_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (done_code_i != CODE_OK)) |=> (rdat_q == '1)); // R6
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !done_i) |=> start_q); // R8
endmodule

// File: rtl/cfgpio_seq.sv
module cfgpio_seq
  import cfgpio_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  pio_req_t          cfg_i,
  output logic              req_valid,
  input  logic              req_ready,
  output pio_req_t          req_o,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [CODE_W-1:0] cpl_code,
  input  logic [WORD_W-1:0] cpl_data,
  output logic              done_o,
  output logic [CODE_W-1:0] done_code_o,
  output logic              done_np_o,
  output logic [WORD_W-1:0] done_data_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(TIMEOUT_CYCLES);

  sq_state_t        state;
  logic [CNT_W-1:0] cnt;
  pio_req_t         held;
  logic             at_limit, send_tmo, wait_tmo, cpl_take;

  always_comb begin
    at_limit = cnt >= LIMIT;
    send_tmo = (state == SQ_SEND) && !req_ready && at_limit;
    cpl_take = (state == SQ_WAIT) && cpl_valid;
    wait_tmo = (state == SQ_WAIT) && !cpl_valid && at_limit;
  end

  assign req_valid   = (state == SQ_SEND);
  assign cpl_ready   = (state == SQ_WAIT);
  assign req_o       = held;
  assign busy_o      = (state != SQ_IDLE);
  assign done_o      = cpl_take || send_tmo || wait_tmo;
  assign done_code_o = cpl_take ? cpl_code : CODE_ABORT;
  assign done_data_o = cpl_take ? cpl_data : '1;
  assign done_np_o   = kind_is_nonposted(held.kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      held  <= '0;
    end else begin
      if (busy_o && (cnt != SAT)) cnt <= cnt + 1'b1;
      case (state)
        SQ_IDLE: if (launch_i) begin
          state     <= SQ_SEND;
          cnt       <= '0;
          held      <= cfg_i;
          held.strb <= kind_is_read(cfg_i.kind) ? '1 : cfg_i.strb;
        end
        SQ_SEND: begin
          if (req_ready)     state <= SQ_WAIT;
          else if (send_tmo) state <= SQ_IDLE;
        end
        SQ_WAIT: if (done_o) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !send_tmo) |=> (req_valid && $stable(req_o))); // R3
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && cpl_ready)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt <= SAT)); // R7
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfgpio_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [3:0]  req_kind,
  output logic [63:0] req_addr,
  output logic [31:0] req_data,
  output logic [3:0]  req_strb,
  output logic        req_nowin,
  input  logic        cpl_valid,
  output logic        cpl_ready,
  input  logic [2:0]  cpl_code,
  input  logic [31:0] cpl_data
);
  pio_req_t          cfg_w, req_w;
  logic              launch_w, start_w, busy_w, done_w, done_np_w;
  logic [CODE_W-1:0] done_code_w;
  logic [WORD_W-1:0] done_data_w;

  cfgpio_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(reg_wr), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .launch_o(launch_w), .cfg_o(cfg_w), .start_o(start_w), .flag_o(irq),
    .done_i(done_w), .done_code_i(done_code_w), .done_np_i(done_np_w), .done_data_i(done_data_w)
  );

  cfgpio_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_w), .cfg_i(cfg_w),
    .req_valid(req_valid), .req_ready(req_ready), .req_o(req_w),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_code(cpl_code), .cpl_data(cpl_data),
    .done_o(done_w), .done_code_o(done_code_w), .done_np_o(done_np_w), .done_data_o(done_data_w),
    .busy_o(busy_w)
  );

  assign req_kind  = req_w.kind;
  assign req_addr  = req_w.addr;
  assign req_data  = req_w.data;
  assign req_strb  = req_w.strb;
  assign req_nowin = req_w.nowin;

  AST_START_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_w == busy_w); // R8
endmodule

// File: tb/cfg_pio_engine_tb.sv
module cfg_pio_engine_tb;
  localparam int T = 16;
  localparam logic [3:0] A_CTRL = 0, A_STAT = 1, A_LO = 2, A_HI = 3, A_WD = 4,
                         A_STRB = 5, A_RD = 6, A_GO = 7, A_FLAG = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, req_valid, req_ready = 1'b0, req_nowin, cpl_valid = 1'b0, cpl_ready;
  logic [3:0]  req_kind, req_strb;
  logic [63:0] req_addr;
  logic [31:0] req_data, cpl_data = '0;
  logic [2:0]  cpl_code = '0;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_pio_engine #(.TIMEOUT_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data), .req_strb(req_strb),
    .req_nowin(req_nowin), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_code(cpl_code), .cpl_data(cpl_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] stat_exp(input logic [2:0] c, input logic [3:0] k);
    return (32'(c) << 7) | ((k >= 4'h8 && k <= 4'hB) ? 32'd1 : 32'd0);
  endfunction

  task automatic launch(input logic [3:0] k, input logic nw, input logic [31:0] lo,
                        input logic [31:0] wd, input logic [3:0] sb);
    wr(A_CTRL, (32'(nw) << 24) | 32'(k));
    wr(A_LO, lo); wr(A_HI, 32'h0); wr(A_WD, wd); wr(A_STRB, 32'(sb));
    wr(A_GO, 32'h1);
  endtask

  task automatic txn(input logic [3:0] k, input logic [2:0] c, input int d, input int dc,
                     input int seed);
    logic [31:0] v, lo, wd, cd;
    logic nw;
    lo = 32'h0123_4567 + 32'(seed) * 32'h0001_1113;
    wd = 32'hA5C3_0000 ^ 32'(seed);
    cd = 32'h5A00_0000 + 32'(seed) * 32'h0000_0101;
    nw = seed[0];
    launch(k, nw, lo, wd, 4'b0110);
    chk("R2 req_valid", 64'(req_valid), 64'd1);
    chk("R2 kind", 64'(req_kind), 64'(k));
    chk("R2 addr", req_addr, {32'h0, lo[31:2], 2'b00});
    chk("R2 data", 64'(req_data), 64'(wd));
    chk("R2 nowin", 64'(req_nowin), 64'(nw));
    chk("R4 strb", 64'(req_strb), (k == 4'h8 || k == 4'h9) ? 64'hF : 64'h6);
    rd(A_GO, v); chk("R2 launch reads 1", 64'(v), 64'd1);
    for (int i = 0; i < d; i++) begin
      @(negedge clk); chk("R3 valid held", 64'(req_valid), 64'd1);
      chk("R3 payload held", req_addr, {32'h0, lo[31:2], 2'b00});
    end
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    chk("R3 valid dropped", 64'(req_valid), 64'd0);
    chk("R3 cpl_ready", 64'(cpl_ready), 64'd1);
    wr(A_GO, 32'h1);
    chk("R8 no relaunch while busy", 64'(req_valid), 64'd0);
    for (int i = 0; i < dc; i++) @(negedge clk);
    cpl_valid = 1'b1; cpl_code = c; cpl_data = cd;
    @(negedge clk); cpl_valid = 1'b0;
    rd(A_GO, v);   chk("R5 launch cleared", 64'(v), 64'd0);
    rd(A_FLAG, v); chk("R5 flag set", 64'(v), 64'd1);
    chk("R9 irq", 64'(irq), 64'd1);
    rd(A_STAT, v); chk("R5 status", 64'(v), 64'(stat_exp(c, k)));
    rd(A_RD, v);   chk("R6 rdata", 64'(v), (c == 3'd0) ? 64'(cd) : 64'hFFFF_FFFF);
    chk("R3 cpl_ready low", 64'(cpl_ready), 64'd0);
    @(negedge clk); chk("R8 no second request", 64'(req_valid), 64'd0);
    wr(A_FLAG, 32'h0); rd(A_FLAG, v); chk("R9 write 0 keeps flag", 64'(v), 64'd1);
    wr(A_FLAG, 32'h1); rd(A_FLAG, v); chk("R9 flag cleared", 64'(v), 64'd0);
    chk("R9 irq low", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0] kinds [5];
    logic [2:0] codes [5];
    kinds = '{4'h8, 4'h9, 4'hA, 4'hB, 4'h3};
    codes = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_GO, v);   chk("R1 launch", 64'(v), 64'd0);
    rd(A_FLAG, v); chk("R1 flag", 64'(v), 64'd0);
    rd(A_STAT, v); chk("R1 status", 64'(v), 64'd0);
    rd(A_RD, v);   chk("R1 rdata", 64'(v), 64'hFFFF_FFFF);
    chk("R1 outputs", {61'd0, req_valid, cpl_ready, irq}, 64'd0);
    // R10 readback of configuration registers
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R10 ctrl", 64'(v), 64'h0100_000F);
    wr(A_HI, 32'h1234_5678);   rd(A_HI, v);   chk("R10 addr hi", 64'(v), 64'h1234_5678);
    wr(A_STRB, 32'hFFFF_FFF9); rd(A_STRB, v); chk("R10 strb", 64'(v), 64'h9);
    // R8 launch write with bit 0 clear
    wr(A_GO, 32'hFFFF_FFFE); rd(A_GO, v); chk("R8 bit0 clear ignored", 64'(v), 64'd0);
    chk("R8 no request", 64'(req_valid), 64'd0);
    // sweep over kinds and completion codes
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        txn(kinds[i], codes[j], (i + j) % 3, j % 4, i * 5 + j);
    // R7 timeout while waiting for a completion
    req_ready = 1'b1;
    launch(4'h8, 1'b0, 32'h0010_8004, 32'h0, 4'hF);
    repeat (T - 1) @(negedge clk);
    rd(A_GO, v); chk("R7 still busy at T-1", 64'(v), 64'd1);
    @(negedge clk);
    rd(A_GO, v);   chk("R7 launch cleared", 64'(v), 64'd0);
    rd(A_FLAG, v); chk("R7 flag", 64'(v), 64'd1);
    rd(A_STAT, v); chk("R7 abort status", 64'(v), 64'h201);
    rd(A_RD, v);   chk("R7 rdata ones", 64'(v), 64'hFFFF_FFFF);
    chk("R7 cpl_ready low", 64'(cpl_ready), 64'd0);
    wr(A_FLAG, 32'h1);
    // R7 completion in last cycle of window wins
    launch(4'h9, 1'b0, 32'h0020_0000, 32'h0, 4'h0);
    repeat (T - 1) @(negedge clk);
    cpl_valid = 1'b1; cpl_code = 3'd0; cpl_data = 32'hCAFE_F00D;
    @(negedge clk); cpl_valid = 1'b0;
    rd(A_STAT, v); chk("R7 late completion status", 64'(v), 64'h1);
    rd(A_RD, v);   chk("R7 late completion data", 64'(v), 64'hCAFE_F00D);
    wr(A_FLAG, 32'h1);
    req_ready = 1'b0;
    // R7 timeout while request never accepted
    launch(4'hA, 1'b1, 32'h0000_0010, 32'h1111_2222, 4'h3);
    repeat (T - 1) @(negedge clk);
    chk("R3 valid held before timeout", 64'(req_valid), 64'd1);
    @(negedge clk);
    chk("R7 send timeout drops valid", 64'(req_valid), 64'd0);
    rd(A_GO, v);   chk("R7 send timeout launch", 64'(v), 64'd0);
    rd(A_STAT, v); chk("R7 send timeout status", 64'(v), 64'h201);
    rd(A_FLAG, v); chk("R7 send timeout flag", 64'(v), 64'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule